// File: doc/BRIEF.md
# Dual-Edge Loadable Shift Register

This block is a small shift register that updates on every transition of a single clock, rising and falling alike. Each update does one of three things: it copies a parallel word into the register, it shifts the contents one place toward the most significant bit with a serial bit entering at the bottom, or it leaves the contents unchanged. An active-high asynchronous clear empties the register at any moment, whatever the clock is doing.

The register is built only from flip-flops that trigger on one edge. A rising-edge bank and a falling-edge bank each store the intended next value XOR the other bank's current contents. The visible word is the XOR of the two banks. After either edge it therefore equals the value the active bank just wrote. The per-edge operation is named by an enumerated selector with three values: `OP_HOLD`, `OP_LOAD` and `OP_SHIFT`. A decoder moves the selector among these values on each edge according to the two control inputs. Load beats shift, and shift beats hold. Several registers chain into a longer one: the top output bit of one stage feeds the serial input of the next, and the clock, controls and clear are shared.

Top module: `dels_shift_reg`

## Requirements
- R1: While `arst` is 1, `par_out` is all zeros within the same time step, and no clock edge changes it, whatever `load_en`, `shift_en` and `par_in` are.
- R2: With `arst` 0 and `load_en` 1, a clock edge copies `par_in` bit for bit into `par_out`, whether `shift_en` is 0 or 1.
- R3: With `arst` 0, `load_en` 0 and `shift_en` 1, a clock edge sets `par_out[0]` to `ser_in` and each `par_out[n]` (n at least 1) to the previous `par_out[n-1]`. The previous top bit `par_out[WIDTH-1]` is lost.
- R4: With `arst` 0, `load_en` 0 and `shift_en` 0, a clock edge leaves `par_out` unchanged.
- R5: The rising edge and the falling edge of `clk` each perform the selected load, shift or hold. Two successive edges therefore perform two operations.
- R6: When two stages share `clk`, `load_en`, `shift_en` and `arst`, and stage A's `par_out[WIDTH-1]` drives stage B's `ser_in`, a shift moves stage A's old top bit into bit 0 of stage B.
- R7: After a clear that is asserted and released between edges, the first edge operates on all-zero contents. For example, a shift with `ser_in` at 1 gives a value of 1 in bit 0 and 0 in every other bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; both transitions are active |
| arst | input | 1 | Asynchronous clear, active high |
| load_en | input | 1 | Parallel load select; has priority over shifting |
| shift_en | input | 1 | Shift enable; takes effect when `load_en` is 0 |
| ser_in | input | 1 | Serial bit entering bit 0 on a shift |
| par_in | input | WIDTH | Parallel load word |
| par_out | output | WIDTH | Register contents, the XOR of the two edge banks |

## Verification
The bound checker records the controls, the serial bit, the load word and the visible contents at every edge of each polarity. At the following edge of the other polarity it confirms that the result is the load word, the shifted word or the unchanged word. It also confirms that the contents stay zero until the first edge after a clear. Those properties cover R1 to R5 on every cycle. The bench's scenarios alone show the effects that fall between or across edges: a clear raised in the middle of a half period, an edge that arrives while the clear is held, operation right after a mid-period release (R7), and the carry of the top bit between two chained stages (R6).

// File: rtl/dels_pkg.sv
`timescale 1ns/1ps
package dels_pkg;

    // Operation applied to the register on one clock edge.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } dels_op_e;

endpackage

// File: rtl/dels_op_decode.sv
`timescale 1ns/1ps
module dels_op_decode
    import dels_pkg::*;
(
    input  logic     load_en,
    input  logic     shift_en,
    output dels_op_e op
);

    // Load outranks shift (R2, R3); with both low the edge holds (R4).
    always_comb begin
        unique case ({load_en, shift_en})
            2'b10, 2'b11: op = OP_LOAD;
            2'b01:        op = OP_SHIFT;
            default:      op = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/dels_next_value.sv
`timescale 1ns/1ps
module dels_next_value
    import dels_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  dels_op_e           op,
    input  logic [WIDTH-1:0]   cur,
    input  logic               ser_in,
    input  logic [WIDTH-1:0]   par_in,
    output logic [WIDTH-1:0]   nxt
);

    localparam int TOP = WIDTH - 1;

    always_comb begin
        unique case (op)
            OP_LOAD:  nxt = par_in;
            OP_SHIFT: nxt = {cur[TOP-1:0], ser_in};
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/dels_edge_bank.sv
`timescale 1ns/1ps
module dels_edge_bank #(
    parameter int WIDTH   = 4,
    parameter bit FALLING = 1'b0
) (
    input  logic             clk,
    input  logic             arst,
    input  logic [WIDTH-1:0] nxt,
    input  logic [WIDTH-1:0] partner,
    output logic [WIDTH-1:0] store
);

    // Writing nxt ^ partner makes (store ^ partner) equal nxt after this edge.
    logic [WIDTH-1:0] enc;
    assign enc = nxt ^ partner;

    generate
        if (FALLING) begin : g_fall
            always_ff @(negedge clk or posedge arst) begin
                if (arst) store <= '0;
                else      store <= enc;
            end
        end else begin : g_rise
            always_ff @(posedge clk or posedge arst) begin
                if (arst) store <= '0;
                else      store <= enc;
            end
        end
    endgenerate

endmodule

// File: rtl/dels_shift_reg.sv
`timescale 1ns/1ps
module dels_shift_reg
    import dels_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             arst,
    input  logic             load_en,
    input  logic             shift_en,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] par_out
);

    initial begin
        if (WIDTH < 2) $error("dels_shift_reg: WIDTH must be at least 2");
    end

    dels_op_e         op;
    logic [WIDTH-1:0] nxt;
    logic [WIDTH-1:0] rise_q;
    logic [WIDTH-1:0] fall_q;

    dels_op_decode u_decode (
        .load_en  (load_en),
        .shift_en (shift_en),
        .op       (op)
    );

    dels_next_value #(.WIDTH(WIDTH)) u_next (
        .op     (op),
        .cur    (par_out),
        .ser_in (ser_in),
        .par_in (par_in),
        .nxt    (nxt)
    );

    dels_edge_bank #(.WIDTH(WIDTH), .FALLING(1'b0)) u_rise (
        .clk     (clk),
        .arst    (arst),
        .nxt     (nxt),
        .partner (fall_q),
        .store   (rise_q)
    );

    dels_edge_bank #(.WIDTH(WIDTH), .FALLING(1'b1)) u_fall (
        .clk     (clk),
        .arst    (arst),
        .nxt     (nxt),
        .partner (rise_q),
        .store   (fall_q)
    );

    assign par_out = rise_q ^ fall_q;

endmodule

// File: rtl/dels_shift_reg_chk.sv
`timescale 1ns/1ps
module dels_shift_reg_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             arst,
    input logic             load_en,
    input logic             shift_en,
    input logic             ser_in,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] par_out
);

    // Snapshot taken at each rising edge, judged at the next falling edge.
    logic             rv, rld, ren, rsi;
    logic [WIDTH-1:0] rd, rq;
    // Snapshot taken at each falling edge, judged at the next rising edge.
    logic             fv, fld, fen, fsi;
    logic [WIDTH-1:0] fd, fq;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            rv <= 1'b0; rld <= 1'b0; ren <= 1'b0; rsi <= 1'b0;
            rd <= '0;   rq  <= '0;
        end else begin
            rv <= 1'b1; rld <= load_en; ren <= shift_en; rsi <= ser_in;
            rd <= par_in; rq <= par_out;
        end
    end

    always_ff @(negedge clk or posedge arst) begin
        if (arst) begin
            fv <= 1'b0; fld <= 1'b0; fen <= 1'b0; fsi <= 1'b0;
            fd <= '0;   fq  <= '0;
        end else begin
            fv <= 1'b1; fld <= load_en; fen <= shift_en; fsi <= ser_in;
            fd <= par_in; fq <= par_out;
        end
    end

    // R1: until the first edge after a clear, the contents stay zero.
    assert_clear_rise_R1: assert property (@(negedge clk) disable iff (arst)
        !rv |-> (par_out == '0));
    assert_clear_fall_R1: assert property (@(posedge clk) disable iff (arst)
        !fv |-> (par_out == '0));

    // R2/R5: a load on either edge.
    assert_load_rise_R2: assert property (@(negedge clk) disable iff (arst)
        (rv && rld) |-> (par_out == rd));
    assert_load_fall_R2: assert property (@(posedge clk) disable iff (arst)
        (fv && fld) |-> (par_out == fd));

    // R3/R5: a shift on either edge.
    assert_shift_rise_R3: assert property (@(negedge clk) disable iff (arst)
        (rv && !rld && ren) |-> (par_out == {rq[WIDTH-2:0], rsi}));
    assert_shift_fall_R3: assert property (@(posedge clk) disable iff (arst)
        (fv && !fld && fen) |-> (par_out == {fq[WIDTH-2:0], fsi}));

    // R4/R5: a hold on either edge.
    assert_hold_rise_R4: assert property (@(negedge clk) disable iff (arst)
        (rv && !rld && !ren) |-> (par_out == rq));
    assert_hold_fall_R4: assert property (@(posedge clk) disable iff (arst)
        (fv && !fld && !fen) |-> (par_out == fq));

endmodule

bind dels_shift_reg dels_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .arst     (arst),
    .load_en  (load_en),
    .shift_en (shift_en),
    .ser_in   (ser_in),
    .par_in   (par_in),
    .par_out  (par_out)
);

// File: tb/dels_shift_reg_tb.sv
`timescale 1ns/1ps
module dels_shift_reg_tb;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         arst = 1'b1;
    logic         load_en = 1'b0;
    logic         shift_en = 1'b0;
    logic         ser_in = 1'b0;
    logic [W-1:0] par_in = '0;
    logic [W-1:0] par_in_b = '0;
    logic [W-1:0] out_a;
    logic [W-1:0] out_b;

    int tests = 0;
    int fails = 0;
    logic [W-1:0] exp_a = '0;
    logic [W-1:0] exp_b = '0;

    always #2.5 clk = ~clk;

    dels_shift_reg #(.WIDTH(W)) u_dut (
        .clk(clk), .arst(arst), .load_en(load_en), .shift_en(shift_en),
        .ser_in(ser_in), .par_in(par_in), .par_out(out_a)
    );

    // Second stage chained from the first stage's top bit (R6).
    dels_shift_reg #(.WIDTH(W)) u_dut_b (
        .clk(clk), .arst(arst), .load_en(load_en), .shift_en(shift_en),
        .ser_in(out_a[W-1]), .par_in(par_in_b), .par_out(out_b)
    );

    function automatic logic [W-1:0] model(input logic [W-1:0] cur,
            input logic ld, input logic en, input logic si, input logic [W-1:0] dv);
        if (ld)      return dv;
        else if (en) return {cur[W-2:0], si};
        else         return cur;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Called shortly after an edge: set inputs, pass one edge, check both stages.
    task automatic step(input logic ld, input logic en, input logic si,
            input logic [W-1:0] dv, input logic [W-1:0] dv2, input string force_tag);
        logic [W-1:0] ea, eb;
        string tag;
        load_en = ld; shift_en = en; ser_in = si; par_in = dv; par_in_b = dv2;
        ea = model(exp_a, ld, en, si, dv);
        eb = model(exp_b, ld, en, exp_a[W-1], dv2);
        @(clk);
        #1;
        if (force_tag != "") tag = force_tag;
        else tag = ld ? "R2" : (en ? "R3" : "R4");
        tag = {tag, clk ? " R5 rising" : " R5 falling"};
        check(tag, out_a, ea);
        check("R6 chained stage", out_b, eb);
        exp_a = ea;
        exp_b = eb;
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED);
        #1;
        check("R1 reset state", out_a, '0);
        @(posedge clk);
        #1;
        check("R1 clear holds through edge", out_a, '0);
        arst = 1'b0;

        // Directed loads on both edges, with and without enable (R2).
        step(1, 0, 0, 4'b1010, 4'b0110, "");
        step(1, 0, 0, 4'b0101, 4'b1001, "");
        step(1, 1, 1, 4'b1000, 4'b0001, "R2 load beats shift");
        // Shifts: the top bit leaves, zeros enter (R3).
        step(0, 1, 0, '0, '0, "R3 top bit dropped");
        step(0, 1, 1, '0, '0, "");
        step(0, 1, 1, '0, '0, "");
        // Holds on both edges (R4).
        step(0, 0, 0, 4'b1111, 4'b1111, "");
        step(0, 0, 1, 4'b1111, 4'b1111, "");

        // Clear raised between edges (R1), an edge under clear, release between edges (R7).
        arst = 1'b1;
        #0.5;
        check("R1 immediate clear", out_a, '0);
        check("R1 immediate clear stage B", out_b, '0);
        load_en = 1'b1; par_in = 4'b1111;
        @(clk);
        #1;
        check("R1 clear overrides load", out_a, '0);
        arst = 1'b0;
        exp_a = '0; exp_b = '0;
        step(0, 1, 1, 4'b1111, '0, "R7 first shift after clear");
        step(0, 1, 0, '0, '0, "R7 second shift after clear");

        // Constrained random mix.
        for (int i = 0; i < 400; i++) begin
            int r;
            logic ld, en;
            r  = $urandom_range(0, 9);
            ld = (r < 2);
            en = (r >= 2 && r < 8);
            step(ld, en, 1'($urandom), W'($urandom), W'($urandom), "");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule